// File: doc/BRIEF.md
# Multi-mode DMA channel engine

The block is one DMA channel. Once armed, it copies items, either bytes or 16-bit words, from a source address to a destination address. It uses a simple synchronous memory port and does one request/ready handshake per access. Each item is one read followed by one write. The channel starts on the one hardware trigger line its configuration selects, or on a software request pulse. When a run completes it raises a sticky interrupt flag.

Four transfer modes set how triggers map to items and what happens at the end of a run:

- single
- block
- repeated single
- repeated block

The repeated modes rearm the channel; the others disarm it. At arm and at every rearm, the engine copies these into working state:

- the source address
- the destination address
- the length
- the transfer settings

The two address pointers then step independently after each item. A variable-length mode reads the run length from the first item moved. That length has a selectable offset, and the configured length acts as a ceiling.

Top module: `dma_chan_engine`

## Requirements
- R1: With mode code 0 (single), each accepted trigger moves exactly one item: one read request, then one write request, after which the channel waits for another trigger.
- R2: With mode codes 0 and 1, the write that completes the run sets the interrupt flag and drops `armed`. Triggers that follow cause no memory access.
- R3: With mode code 1 (block), one trigger moves every item of the run. Each new read request is issued in the cycle after the previous write is accepted.
- R4: With mode codes 2 (repeated single) and 3 (repeated block), completion sets the interrupt flag but `armed` stays high. The pointers, count and settings are reloaded from the current configuration inputs.
- R5: A trigger is `trig_in[sel]` high in a cycle while the channel is waiting, where `sel` is the captured select value. A high `sw_req` in such a cycle is also a trigger. Other trigger lines have no effect.
- R6: Triggers and software requests that arrive while the channel is disarmed, or while an item or block is in progress, are dropped and do not start further items.
- R7: `cfg_wide`=1 selects 16-bit items: `mem_wide` is 1 and the full read word is written. `cfg_wide`=0 selects bytes: `mem_wide` is 0 and the write data is the low read byte with its upper byte zero.
- R8: The step codes are: 00 no change, 01 +1 item, 10 +2 items, 11 −1 item. One item is 1 byte for bytes and 2 bytes for words. Each pointer steps after every completed write.
- R9: The variable-length code `cfg_var` works as follows, where n is the first read item (low byte only for byte items):
  - 1: n+1 items in total, the length item included.
  - 2: n items in total.
  - 3: n+2 items in total.
  - 4: n+3 items in total.
  - 0 and 5 to 7: fixed length.
- R10: In variable-length mode the configured length is a ceiling: a computed total greater than or equal to it yields the configured length. A computed total of 0 yields 1, because the length item has already moved.
- R11: The interrupt flag stays set until `irq_clr` is high. A completion in the same cycle takes priority over the clear.
- R12: On arm or rearm, a configured length of 0 leaves the channel disarmed, with no access and no interrupt. An arm pulse while already armed is ignored.
- R13: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` is high in the same cycle.
- R14: After reset, `mem_req`, `irq` and `armed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm pulse; captures the configuration |
| cfg_src | input | AW | Source start address (bytes) |
| cfg_dst | input | AW | Destination start address (bytes) |
| cfg_len | input | LW | Item count, or ceiling in variable-length mode |
| cfg_var | input | 3 | Variable-length code |
| cfg_wide | input | 1 | 1 = 16-bit items, 0 = bytes |
| cfg_mode | input | 2 | 0 single, 1 block, 2 repeated single, 3 repeated block |
| cfg_trig | input | TSW | Hardware trigger select |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| trig_in | input | NTRIG | Hardware trigger lines |
| sw_req | input | 1 | Software request pulse |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky completion flag |
| armed | output | 1 | Channel armed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access is a 16-bit item |
| mem_addr | output | AW | Byte address of access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current access |

## Verification
The hardest case to reach is the end of a repeated run when the configured length has been changed to zero mid-run. The current run must still finish on its captured length, and only the rearm may then see zero and disarm. The stimulus arms a repeated channel, lets one run finish to confirm the rearm, and then writes length 0. It triggers the second run and checks that all of its items move before `armed` falls. Variable-length totals are driven by a bench memory that returns a chosen length value at the run's source address. This covers each offset code, the ceiling and the zero-length item. A ready pattern that inserts wait cycles holds every access across extra cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int DW = 16;

    typedef enum logic [1:0] {
        XM_SINGLE  = 2'd0,
        XM_BLOCK   = 2'd1,
        XM_RSINGLE = 2'd2,
        XM_RBLOCK  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        PS_OFF,
        PS_WAIT,
        PS_READ,
        PS_WRITE
    } phase_e;

    typedef enum logic [1:0] {
        SP_HOLD  = 2'd0,
        SP_UP1   = 2'd1,
        SP_UP2   = 2'd2,
        SP_DOWN1 = 2'd3
    } step_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic [2:0] var_code;
        logic       wide;
        step_e      src_step;
        step_e      dst_step;
    } run_cfg_t;

    // byte delta applied to a pointer after one item
    function automatic logic signed [3:0] step_bytes(step_e s, logic wide);
        logic signed [3:0] unit;
        unit = wide ? 4'sd2 : 4'sd1;
        case (s)
            SP_UP1:   return unit;
            SP_UP2:   return unit <<< 1;
            SP_DOWN1: return -unit;
            default:  return 4'sd0;
        endcase
    endfunction

    function automatic logic is_var(logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction

    // items added to the length value n
    function automatic logic [1:0] var_extra(logic [2:0] c);
        case (c)
            3'd1:    return 2'd1;
            3'd3:    return 2'd2;
            3'd4:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic mode_repeats(xfer_mode_e m);
        return m == XM_RSINGLE || m == XM_RBLOCK;
    endfunction

    function automatic logic mode_burst(xfer_mode_e m);
        return m == XM_BLOCK || m == XM_RBLOCK;
    endfunction

endpackage

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr
    import dma_chan_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  step_e         step,
    input  logic          wide,
    output logic [AW-1:0] ptr
);

    logic signed [3:0] delta;
    logic [AW-1:0]     delta_ext;

    assign delta     = step_bytes(step, wide);
    assign delta_ext = {{(AW-4){delta[3]}}, delta};

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= base;
        else if (adv)  ptr <= ptr + delta_ext;
    end

endmodule

// File: rtl/dma_chan_len.sv
module dma_chan_len
    import dma_chan_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] lim,
    input  logic          rd_ok,
    input  logic [DW-1:0] rdata,
    input  logic          wide,
    input  logic [2:0]    var_code,
    input  logic          adv,
    output logic          last
);

    localparam int SW = ((LW > DW) ? LW : DW) + 2;

    logic [LW-1:0] cnt;
    logic [LW-1:0] tot;
    logic [DW-1:0] n_val;
    logic [SW-1:0] ext;
    logic          head;

    assign head  = (cnt == '0);
    assign n_val = wide ? rdata : {8'h00, rdata[7:0]};
    assign ext   = SW'(n_val) + SW'(var_extra(var_code));
    assign last  = ({1'b0, cnt} + 1'b1) == {1'b0, tot};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tot <= '0;
        end else if (load) begin
            cnt <= '0;
            tot <= lim;
        end else begin
            if (rd_ok && head && is_var(var_code) && (ext < SW'(tot)))
                tot <= (ext == '0) ? LW'(1) : ext[LW-1:0];
            if (adv)
                cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        adv |-> (cnt < tot));

    p_tot_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && !load) |=> (tot != '0));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       len_zero,
    input  logic       hit,
    input  logic       ready,
    input  logic       last,
    input  xfer_mode_e mode,
    output phase_e     ph,
    output logic       load,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       done
);

    logic rearm;

    assign rd_ok = (ph == PS_READ) && ready;
    assign wr_ok = (ph == PS_WRITE) && ready;
    assign done  = wr_ok && last;
    assign rearm = done && mode_repeats(mode) && !len_zero;
    assign load  = ((ph == PS_OFF) && arm && !len_zero) || rearm;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PS_OFF;
        end else begin
            case (ph)
                PS_OFF:   if (arm && !len_zero) ph <= PS_WAIT;
                PS_WAIT:  if (hit) ph <= PS_READ;
                PS_READ:  if (ready) ph <= PS_WRITE;
                PS_WRITE: if (ready) begin
                    if (done)                  ph <= rearm ? PS_WAIT : PS_OFF;
                    else if (mode_burst(mode)) ph <= PS_READ;
                    else                       ph <= PS_WAIT;
                end
                default:  ph <= PS_OFF;
            endcase
        end
    end

    p_len0_off_r12: assert property (@(posedge clk) disable iff (rst)
        (ph == PS_OFF && arm && len_zero) |=> (ph == PS_OFF));

    p_read_then_write_r1: assert property (@(posedge clk) disable iff (rst)
        rd_ok |=> (ph == PS_WRITE));

    p_single_waits_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !last && !mode_burst(mode)) |=> (ph == PS_WAIT));

    p_block_continues_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !last && mode_burst(mode)) |=> (ph == PS_READ));

    p_done_disarms_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_repeats(mode)) |=> (ph == PS_OFF));

    p_rearm_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (done && mode_repeats(mode) && !len_zero) |=> (ph == PS_WAIT));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LW    = 10,
    parameter int NTRIG = 8,
    localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [LW-1:0]    cfg_len,
    input  logic [2:0]       cfg_var,
    input  logic             cfg_wide,
    input  logic [1:0]       cfg_mode,
    input  logic [TSW-1:0]   cfg_trig,
    input  logic [1:0]       cfg_src_step,
    input  logic [1:0]       cfg_dst_step,
    input  logic [NTRIG-1:0] trig_in,
    input  logic             sw_req,
    input  logic             irq_clr,
    output logic             irq,
    output logic             armed,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready
);

    run_cfg_t      rc;
    logic [TSW-1:0] sel_q;
    logic [DW-1:0] data_q;
    phase_e        ph;
    logic          load, rd_ok, wr_ok, done, last, hit, len_zero;
    logic [AW-1:0] src_ptr, dst_ptr;

    assign len_zero = (cfg_len == '0);
    assign hit      = trig_in[sel_q] | sw_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc     <= '0;
            sel_q  <= '0;
            data_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (load) begin
                rc    <= '{mode:     xfer_mode_e'(cfg_mode),
                           var_code: cfg_var,
                           wide:     cfg_wide,
                           src_step: step_e'(cfg_src_step),
                           dst_step: step_e'(cfg_dst_step)};
                sel_q <= cfg_trig;
            end
            if (rd_ok)
                data_q <= mem_rdata;
            if (done)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

    dma_chan_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .len_zero (len_zero),
        .hit      (hit),
        .ready    (mem_ready),
        .last     (last),
        .mode     (rc.mode),
        .ph       (ph),
        .load     (load),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .done     (done)
    );

    dma_chan_len #(.LW(LW)) u_len (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .lim      (cfg_len),
        .rd_ok    (rd_ok),
        .rdata    (mem_rdata),
        .wide     (rc.wide),
        .var_code (rc.var_code),
        .adv      (wr_ok),
        .last     (last)
    );

    dma_chan_ptr #(.AW(AW)) u_src (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .base (cfg_src),
        .adv  (wr_ok),
        .step (rc.src_step),
        .wide (rc.wide),
        .ptr  (src_ptr)
    );

    dma_chan_ptr #(.AW(AW)) u_dst (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .base (cfg_dst),
        .adv  (wr_ok),
        .step (rc.dst_step),
        .wide (rc.wide),
        .ptr  (dst_ptr)
    );

    assign armed     = (ph != PS_OFF);
    assign mem_req   = (ph == PS_READ) || (ph == PS_WRITE);
    assign mem_we    = (ph == PS_WRITE);
    assign mem_wide  = mem_req && rc.wide;
    assign mem_addr  = mem_we ? dst_ptr : src_ptr;
    assign mem_wdata = !mem_we ? '0 : (rc.wide ? data_q : {8'h00, data_q[7:0]});

    p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    p_irq_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ready));

    p_off_no_access_r6: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm) |=> !mem_req);

endmodule

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/100ps
module sim_dma_chan_engine;

    localparam int AW = 16;
    localparam int LW = 10;
    localparam int NT = 8;

    logic clk = 0;
    logic rst = 1;
    logic arm = 0;
    logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
    logic [LW-1:0] cfg_len = 0;
    logic [2:0] cfg_var = 0;
    logic cfg_wide = 0;
    logic [1:0] cfg_mode = 0;
    logic [2:0] cfg_trig = 0;
    logic [1:0] cfg_src_step = 0, cfg_dst_step = 0;
    logic [NT-1:0] trig_in = 0;
    logic sw_req = 0, irq_clr = 0;
    logic irq, armed, mem_req, mem_we, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic mem_ready = 0;

    int compared = 0, mismatched = 0, wcount = 0;
    logic [15:0] len_addr = 16'hFFFF;
    logic [15:0] len_val = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_chan_engine #(.AW(AW), .LW(LW), .NTRIG(NT)) u0 (
        .clk(clk), .rst(rst), .arm(arm), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_len(cfg_len), .cfg_var(cfg_var), .cfg_wide(cfg_wide), .cfg_mode(cfg_mode),
        .cfg_trig(cfg_trig), .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .trig_in(trig_in), .sw_req(sw_req), .irq_clr(irq_clr), .irq(irq), .armed(armed),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

    function automatic logic [15:0] rd_fn(logic [15:0] a);
        if (a == len_addr) return len_val;
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
    endfunction

    assign mem_rdata = rd_fn(mem_addr);

    // memory ready pattern: wait cycles at two of every seven
    int rpos = 0;
    always @(negedge clk) begin
        rpos = (rpos + 1) % 7;
        mem_ready = (rpos != 2) && (rpos != 5);
    end

    // behavioural reference
    int m_ph, m_src, m_dst, m_cnt, m_tot, m_data, m_mode, m_var, m_ss, m_ds, m_sel;
    bit m_word, m_irq;

    function automatic int stepv(int s, bit w);
        int u;
        u = w ? 2 : 1;
        case (s)
            1: return u;
            2: return 2 * u;
            3: return -u;
            default: return 0;
        endcase
    endfunction

    task automatic m_load();
        m_src = cfg_src; m_dst = cfg_dst; m_cnt = 0; m_tot = cfg_len;
        m_mode = cfg_mode; m_var = cfg_var; m_word = cfg_wide;
        m_ss = cfg_src_step; m_ds = cfg_dst_step; m_sel = cfg_trig;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_tot = 0; m_data = 0;
            m_irq = 0; m_mode = 0; m_var = 0; m_word = 0; m_ss = 0; m_ds = 0; m_sel = 0;
        end else begin
            bit fin;
            fin = 0;
            case (m_ph)
                0: if (arm && cfg_len != 0) begin m_load(); m_ph = 1; end
                1: if (trig_in[m_sel] || sw_req) m_ph = 2;
                2: if (mem_ready) begin
                    m_data = rd_fn(m_src[15:0]);
                    if (m_cnt == 0 && m_var >= 1 && m_var <= 4) begin
                        int n, t;
                        n = m_word ? m_data : (m_data & 255);
                        t = n + (m_var == 1 ? 1 : m_var == 2 ? 0 : m_var == 3 ? 2 : 3);
                        if (t < m_tot) m_tot = (t == 0) ? 1 : t;
                    end
                    m_ph = 3;
                end
                default: if (mem_ready) begin
                    m_src = (m_src + stepv(m_ss, m_word)) & 16'hFFFF;
                    m_dst = (m_dst + stepv(m_ds, m_word)) & 16'hFFFF;
                    m_cnt++;
                    if (m_cnt == m_tot) begin
                        fin = 1;
                        if (m_mode >= 2 && cfg_len != 0) begin m_load(); m_ph = 1; end
                        else m_ph = 0;
                    end else m_ph = (m_mode == 1 || m_mode == 3) ? 2 : 1;
                end
            endcase
            if (fin) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #0.5;
        if (!finished) begin
            bit e_req, e_we;
            e_req = (m_ph == 2 || m_ph == 3);
            e_we  = (m_ph == 3);
            chk("R13 mem_req", mem_req, e_req);
            if (e_req && mem_req) begin
                chk("R13 mem_we", mem_we, e_we);
                chk("R8 mem_addr", mem_addr, e_we ? m_dst : m_src);
                chk("R7 mem_wide", mem_wide, m_word);
                if (e_we) chk("R7 mem_wdata", mem_wdata, m_word ? m_data : (m_data & 255));
            end
            chk("R11 irq", irq, m_irq);
            chk("R2 armed", armed, (m_ph != 0));
            if (mem_req && mem_we && mem_ready) wcount++;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1; @(negedge clk); arm = 0;
    endtask

    task automatic pulse_trig(int i);
        @(negedge clk); trig_in[i] = 1; @(negedge clk); trig_in = 0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_req = 1; @(negedge clk); sw_req = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    endtask

    task automatic setup(int src, int dst, int len, int mode, bit wide,
                         int ss, int ds, int sel, int vc);
        @(negedge clk);
        cfg_src = src[15:0]; cfg_dst = dst[15:0]; cfg_len = len[LW-1:0];
        cfg_mode = mode[1:0]; cfg_wide = wide; cfg_src_step = ss[1:0];
        cfg_dst_step = ds[1:0]; cfg_trig = sel[2:0]; cfg_var = vc[2:0];
    endtask

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #600000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic var_case(int code, int n, int exp_items);
        setup(16'h0800, 16'h0900, 10, 1, 0, 1, 1, 0, code);
        len_addr = 16'h0800; len_val = n[15:0];
        wcount = 0;
        pulse_arm(); pulse_sw(); wait_n(60);
        chk(code >= 1 && code <= 4 ? "R9 var items" : "R9 fixed items", wcount, exp_items);
        chk("R10 var irq", irq, 1);
        pulse_clr();
        len_addr = 16'hFFFF;
    endtask

    initial begin
        wait_n(4);
        chk("R14 irq reset", irq, 0);
        chk("R14 armed reset", armed, 0);
        chk("R14 req reset", mem_req, 0);
        rst = 0;
        wait_n(2);

        // single, byte, select line 2
        setup(16'h0100, 16'h0200, 3, 0, 0, 1, 2, 2, 0);
        wcount = 0;
        pulse_arm();
        pulse_trig(5); wait_n(10);
        chk("R5 other line ignored", wcount, 0);
        pulse_trig(2); wait_n(12);
        chk("R1 one item per trigger", wcount, 1);
        chk("R1 still armed", armed, 1);
        pulse_trig(2); wait_n(12);
        pulse_trig(2); wait_n(12);
        chk("R2 single count", wcount, 3);
        chk("R2 disarmed", armed, 0);
        pulse_trig(2); wait_n(12);
        chk("R2 trigger after done ignored", wcount, 3);
        chk("R11 irq sticky", irq, 1);
        pulse_clr(); wait_n(1);
        chk("R11 irq cleared", irq, 0);

        // block, word, software request, extra triggers during block
        setup(16'h0400, 16'h0500, 4, 1, 1, 3, 1, 1, 0);
        wcount = 0;
        pulse_arm(); pulse_sw();
        wait_n(2); pulse_sw(); pulse_trig(1);
        wait_n(40);
        chk("R3 block moved all", wcount, 4);
        chk("R6 extra triggers ignored", armed, 0);
        chk("R7 word irq", irq, 1);
        pulse_clr();

        // repeated single, then length 0 at rearm
        setup(16'h0600, 16'h0700, 2, 2, 0, 0, 3, 0, 0);
        wcount = 0;
        pulse_arm();
        pulse_trig(0); wait_n(12);
        pulse_trig(0); wait_n(12);
        chk("R4 repeated irq", irq, 1);
        chk("R4 rearmed", armed, 1);
        pulse_clr();
        pulse_trig(0); wait_n(12);
        chk("R4 run after rearm", wcount, 3);
        @(negedge clk); cfg_len = 0;
        pulse_trig(0); wait_n(12);
        chk("R12 rearm with zero length", armed, 0);
        chk("R12 captured length finished", wcount, 4);
        pulse_clr();

        // repeated block
        setup(16'h0A00, 16'h0B00, 3, 3, 1, 1, 2, 4, 0);
        wcount = 0;
        pulse_arm(); pulse_sw(); wait_n(40);
        chk("R4 repeated block items", wcount, 3);
        chk("R4 repeated block armed", armed, 1);
        @(negedge clk); cfg_len = 0;
        pulse_sw(); wait_n(40);
        chk("R4 second block items", wcount, 6);
        chk("R12 block disarmed", armed, 0);
        pulse_clr();

        // variable length codes
        var_case(1, 3, 4);
        var_case(2, 3, 3);
        var_case(3, 3, 5);
        var_case(4, 3, 6);
        var_case(1, 20, 10);
        var_case(3, 7, 9);
        var_case(4, 7, 10);
        var_case(2, 0, 1);
        var_case(1, 16'h0503, 4);
        var_case(0, 3, 10);
        var_case(5, 3, 10);

        // zero length arm
        setup(16'h0C00, 16'h0D00, 0, 1, 0, 1, 1, 0, 0);
        wcount = 0;
        pulse_arm(); pulse_sw(); wait_n(12);
        chk("R12 zero length stays off", armed, 0);
        chk("R12 zero length no access", wcount, 0);
        chk("R12 zero length no irq", irq, 0);

        // arm while armed is ignored
        setup(16'h0E00, 16'h0F00, 2, 0, 0, 1, 0, 1, 0);
        wcount = 0;
        pulse_arm(); pulse_trig(1); wait_n(12);
        @(negedge clk); cfg_src = 16'h1200;
        pulse_arm(); pulse_trig(1); wait_n(12);
        chk("R12 rearm pulse ignored count", wcount, 2);
        chk("R12 rearm pulse ignored irq", irq, 1);

        wait_n(4);
        summary();
    end

endmodule